// File: doc/BRIEF.md
# Cartridge Bank Mapper with Sound Window

This block decodes the 64 KB address space of an 8-bit CPU into four 8 KB windows onto a larger ROM. Each window has a bank register. The ROM address is the selected bank number joined to the low 13 bits of the CPU address. The four windows sit at 4000h, 6000h, 8000h and A000h. The remaining quarters of the space alias onto them: C000h onto window 0, E000h onto window 1, 0000h onto window 2 and 2000h onto window 3.

The CPU changes a bank by writing to a 2 KB slice in the upper half of each window. Any address in that slice selects the same register. When the bank register of window 2 holds the value 3Fh, a sound-register window opens at 9800h-9FFFh. Accesses there go to a sound block instead of ROM, and the sound block sees an 8-bit offset that repeats every 256 bytes. The ROM is read-only, so writes to any other mapped address are dropped.

Top module: `cart_mapper`

## Requirements
- R1: After a synchronous reset, windows 0, 1, 2 and 3 hold banks 0, 1, 2 and 3. Reads at 4000h, 6000h, 8000h and A000h produce ROM addresses 00000h, 02000h, 04000h and 06000h.
- R2: Page index is {~cpu_addr[14], cpu_addr[13]}. C000h-DFFFh uses window 0, E000h-FFFFh window 1, 0000h-1FFFh window 2 and 2000h-3FFFh window 3. The ROM address is {bank, cpu_addr[12:0]}.
- R3: A write with cpu_addr[15:14] equal to 01b or 10b and cpu_addr[12:11] equal to 10b loads the bank register of that page (5000h-57FFh for page 0, 7000h-77FFh for page 1, 9000h-97FFh for page 2, B000h-B7FFh for page 3). The new bank is used from the next clock cycle.
- R4: A bank write keeps only the low 6 bits of cpu_wdata.
- R5: A write to any other address leaves every bank register unchanged. This covers the mapped area, the upper 2 KB of a window and the aliased quarters.
- R6: When the page-2 bank equals 3Fh, a read or write to 9800h-9FFFh raises snd_sel and holds rom_rd low. The other addresses of page 2 still read ROM.
- R7: While snd_sel is high, snd_ofs equals cpu_addr[7:0], so the 256-byte register set repeats across the window.
- R8: When the page-2 bank is not 3Fh, 9800h-9FFFh reads ROM. The alias 1800h-1FFFh never raises snd_sel.
- R9: rom_rd is high only for a read outside an open sound window. With neither strobe active, both rom_rd and snd_sel are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 19 | ROM address {bank, offset} |
| rom_rd | output | 1 | ROM read enable |
| snd_sel | output | 1 | Access targets the sound register window |
| snd_ofs | output | 8 | Register offset inside the sound window |

## Verification
The assertions check several properties on every cycle:
- each bank register changes only in the cycle after a write aimed at it;
- the ROM read and the sound select are never active together;
- the sound select appears only while page 2 holds the magic bank;
- writes never strobe the ROM.

Only the bench scenarios can show the remaining behaviour:
- the exact ROM addresses produced for each window and its alias;
- the masking of written data to 6 bits;
- the window closing after page 2 is moved off the magic value;
- the reset state after the banks have been changed.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int CPU_AW     = 16;
    localparam int OFS_W      = 13;
    localparam int PAGE_CNT   = 4;
    localparam int PAGE_IDX_W = $clog2(PAGE_CNT);
    localparam int SND_OFS_W  = 8;

    typedef logic [PAGE_IDX_W-1:0] page_t;
    typedef logic [CPU_AW-1:0]     cpu_addr_t;

    typedef struct packed {
        cpu_addr_t  addr;
        logic [7:0] wdata;
        logic       wr;
        logic       rd;
    } cpu_req_t;

    typedef struct packed {
        page_t      page;
        logic       bank_hit;
        logic       snd_range;
    } decode_t;

    // windows at 4000h,6000h,8000h,A000h are pages 0..3; the other quarters alias
    function automatic page_t page_of(cpu_addr_t a);
        return {~a[14], a[13]};
    endfunction

    // bank-select slice: xx00h-x7FFh of 5000h,7000h,9000h,B000h
    function automatic logic is_bank_slice(cpu_addr_t a);
        return (a[15:14] == 2'b01 || a[15:14] == 2'b10) && (a[12:11] == 2'b10);
    endfunction

    // 9800h-9FFFh
    function automatic logic is_snd_range(cpu_addr_t a);
        return a[15:11] == 5'b10011;
    endfunction
endpackage

// File: rtl/mapper_page_decode.sv
module mapper_page_decode
    import mapper_pkg::*;
(
    input  cpu_addr_t addr,
    output decode_t   dec
);
    always_comb begin
        dec.page      = page_of(addr);
        dec.bank_hit  = is_bank_slice(addr);
        dec.snd_range = is_snd_range(addr);
    end
endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
    import mapper_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  page_t                              wr_page,
    input  logic [7:0]                         wr_data,
    output logic [PAGE_CNT-1:0][BANK_W-1:0]    bank_q
);
    for (genvar k = 0; k < PAGE_CNT; k++) begin : g_page
        localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(k);

        always_ff @(posedge clk) begin
            if (rst)
                bank_q[k] <= RST_BANK;
            else if (wr_en && wr_page == page_t'(k))
                bank_q[k] <= wr_data[BANK_W-1:0];
        end

        // R5
        bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_page == page_t'(k)) |=> $stable(bank_q[k]));
    end
endmodule

// File: rtl/mapper_snd_window.sv
module mapper_snd_window
    import mapper_pkg::*;
#(
    parameter int              BANK_W = 6,
    parameter logic [BANK_W-1:0] MAGIC = '1
) (
    input  logic [BANK_W-1:0]     page2_bank,
    input  decode_t               dec,
    input  cpu_req_t              req,
    output logic                  hit,
    output logic                  sel,
    output logic [SND_OFS_W-1:0]  ofs
);
    logic open_q;

    always_comb begin
        open_q = (page2_bank == MAGIC);
        hit    = open_q && dec.snd_range;
        sel    = hit && (req.rd || req.wr);
        ofs    = req.addr[SND_OFS_W-1:0];
    end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import mapper_pkg::*;
#(
    parameter int              BANK_W      = 6,
    parameter logic [BANK_W-1:0] MAGIC_BANK = 6'h3F,
    localparam int             ROM_AW      = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd,
    output logic              snd_sel,
    output logic [7:0]        snd_ofs
);
    cpu_req_t                            req;
    decode_t                             dec;
    logic [PAGE_CNT-1:0][BANK_W-1:0]     bank_q;
    logic                                snd_hit;
    logic                                bank_wr;

    assign req = '{addr: cpu_addr, wdata: cpu_wdata, wr: cpu_wr, rd: cpu_rd};

    mapper_page_decode u_dec (
        .addr (req.addr),
        .dec  (dec)
    );

    assign bank_wr = req.wr && dec.bank_hit;

    mapper_bank_regs #(.BANK_W(BANK_W)) u_banks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bank_wr),
        .wr_page (dec.page),
        .wr_data (req.wdata),
        .bank_q  (bank_q)
    );

    mapper_snd_window #(.BANK_W(BANK_W), .MAGIC(MAGIC_BANK)) u_snd (
        .page2_bank (bank_q[2]),
        .dec        (dec),
        .req        (req),
        .hit        (snd_hit),
        .sel        (snd_sel),
        .ofs        (snd_ofs)
    );

    always_comb begin
        rom_addr = {bank_q[dec.page], req.addr[OFS_W-1:0]};
        rom_rd   = req.rd && !snd_hit;
    end

    // R6
    rom_snd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rom_rd && snd_sel));

    // R6
    snd_magic_chk: assert property (@(posedge clk) disable iff (rst)
        snd_sel |-> (bank_q[2] == MAGIC_BANK));

    // R9
    rom_rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rom_rd |-> cpu_rd);

    // R9
    wr_no_rom_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_rd) |-> !rom_rd);
endmodule

// File: tb/cart_mapper_bench.sv
module cart_mapper_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wr, cpu_rd;
    logic [18:0] rom_addr;
    logic        rom_rd, snd_sel;
    logic [7:0]  snd_ofs;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    cart_mapper u_cart_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr),
        .rom_rd(rom_rd), .snd_sel(snd_sel), .snd_ofs(snd_ofs)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [18:0] erom;
        logic        erd;
        logic        esel;
        logic [7:0]  eofs;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,16'h4000,8'h00,19'h00000,1'b1,1'b0,8'h00,4'd1}, // R1
        '{1'b0,1'b1,16'h6123,8'h00,19'h02123,1'b1,1'b0,8'h00,4'd1}, // R1
        '{1'b0,1'b1,16'h8000,8'h00,19'h04000,1'b1,1'b0,8'h00,4'd1}, // R1
        '{1'b0,1'b1,16'hBFFF,8'h00,19'h07FFF,1'b1,1'b0,8'h00,4'd1}, // R1
        '{1'b0,1'b1,16'hC010,8'h00,19'h00010,1'b1,1'b0,8'h00,4'd2}, // R2
        '{1'b0,1'b1,16'hE000,8'h00,19'h02000,1'b1,1'b0,8'h00,4'd2}, // R2
        '{1'b0,1'b1,16'h0005,8'h00,19'h04005,1'b1,1'b0,8'h00,4'd2}, // R2
        '{1'b0,1'b1,16'h3FFF,8'h00,19'h07FFF,1'b1,1'b0,8'h00,4'd2}, // R2
        '{1'b1,1'b0,16'h5000,8'h05,19'h01000,1'b0,1'b0,8'h00,4'd3}, // R3
        '{1'b0,1'b1,16'h4000,8'h00,19'h0A000,1'b1,1'b0,8'h00,4'd3}, // R3
        '{1'b1,1'b0,16'h77FF,8'hC7,19'h037FF,1'b0,1'b0,8'h00,4'd4}, // R4
        '{1'b0,1'b1,16'h6000,8'h00,19'h0E000,1'b1,1'b0,8'h00,4'd4}, // R4
        '{1'b1,1'b0,16'h4000,8'h2A,19'h0A000,1'b0,1'b0,8'h00,4'd5}, // R5
        '{1'b1,1'b0,16'h5800,8'h11,19'h0B800,1'b0,1'b0,8'h00,4'd5}, // R5
        '{1'b1,1'b0,16'hD000,8'h11,19'h0B000,1'b0,1'b0,8'h00,4'd5}, // R5
        '{1'b0,1'b1,16'h4000,8'h00,19'h0A000,1'b1,1'b0,8'h00,4'd5}, // R5
        '{1'b0,1'b1,16'h9800,8'h00,19'h05800,1'b1,1'b0,8'h00,4'd8}, // R8
        '{1'b1,1'b0,16'h9000,8'h3F,19'h05000,1'b0,1'b0,8'h00,4'd3}, // R3
        '{1'b0,1'b1,16'h9800,8'h00,19'h7F800,1'b0,1'b1,8'h00,4'd6}, // R6
        '{1'b0,1'b1,16'h9F42,8'h00,19'h7FF42,1'b0,1'b1,8'h42,4'd7}, // R7
        '{1'b1,1'b0,16'h98A0,8'h55,19'h7F8A0,1'b0,1'b1,8'hA0,4'd6}, // R6
        '{1'b0,1'b1,16'h9000,8'h00,19'h7F000,1'b1,1'b0,8'h00,4'd6}, // R6
        '{1'b0,1'b1,16'h1800,8'h00,19'h7F800,1'b1,1'b0,8'h00,4'd8}, // R8
        '{1'b1,1'b0,16'h97FF,8'hFF,19'h7F7FF,1'b0,1'b0,8'h00,4'd4}, // R4
        '{1'b0,1'b1,16'h9800,8'h00,19'h7F800,1'b0,1'b1,8'h00,4'd4}, // R4
        '{1'b1,1'b0,16'hB000,8'h40,19'h07000,1'b0,1'b0,8'h00,4'd3}, // R3
        '{1'b0,1'b1,16'hA000,8'h00,19'h00000,1'b1,1'b0,8'h00,4'd3}, // R3
        '{1'b1,1'b0,16'h9400,8'h3E,19'h7F400,1'b0,1'b0,8'h00,4'd8}, // R8
        '{1'b0,1'b1,16'h9800,8'h00,19'h7D800,1'b1,1'b0,8'h00,4'd8}, // R8
        '{1'b0,1'b0,16'h9800,8'h00,19'h7D800,1'b0,1'b0,8'h00,4'd9}  // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
        #2;
    endtask

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].wr, TBL[i].rd, TBL[i].addr, TBL[i].data);
            check($sformatf("R%0d rom_addr row %0d", TBL[i].req, i), 32'(rom_addr), 32'(TBL[i].erom));
            check($sformatf("R%0d rom_rd row %0d", TBL[i].req, i), 32'(rom_rd), 32'(TBL[i].erd));
            check($sformatf("R%0d snd_sel row %0d", TBL[i].req, i), 32'(snd_sel), 32'(TBL[i].esel));
            if (TBL[i].esel)
                check($sformatf("R%0d snd_ofs row %0d", TBL[i].req, i), 32'(snd_ofs), 32'(TBL[i].eofs));
        end

        // R7: reopen window, offset repeats across the 256-byte mirrors
        drive(1'b1, 1'b0, 16'h9000, 8'h3F);
        drive(1'b0, 1'b1, 16'h9E5A, 8'h00);
        check("R7 snd_ofs 9E5A", 32'(snd_ofs), 32'h5A);
        check("R7 snd_sel 9E5A", 32'(snd_sel), 32'h1);
        drive(1'b0, 1'b1, 16'h985A, 8'h00);
        check("R7 snd_ofs 985A", 32'(snd_ofs), 32'h5A);

        // R1: reset after banks were changed restores linear layout
        @(negedge clk) rst = 1'b1; cpu_rd = 0; cpu_wr = 0;
        @(negedge clk) rst = 1'b0;
        drive(1'b0, 1'b1, 16'h4000, 8'h00);
        check("R1 reset page0", 32'(rom_addr), 32'h00000);
        drive(1'b0, 1'b1, 16'h9800, 8'h00);
        check("R1 reset page2", 32'(rom_addr), 32'h05800);
        check("R1 reset no window", 32'(snd_sel), 32'h0);
        drive(1'b0, 1'b1, 16'hA000, 8'h00);
        check("R1 reset page3", 32'(rom_addr), 32'h06000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule